// File: doc/BRIEF.md
# Single-Port Synchronous SRAM with Grouped Write Enables

This block is a synthesizable model of a one-port synchronous memory. It has a rising-edge clock and an active-low chip select. A write-enable bus carries one bit per group of data bits, so any subset of a word's groups can be updated in one cycle. The word read last sits in an output register. A separate active-high output enable either drives that register onto a shared data bus or releases the bus.

A small cycle-type state machine classifies every clock edge as one of three states. `S_IDLE` means the chip is deselected. `S_READ` means selected with all write-enable bits low. `S_WRITE` means selected with at least one write-enable bit high. Every state can move to every other state on any edge. The move is chosen only by that edge's chip select and write-enable inputs:
- deselect leads to `S_IDLE`;
- select with an all-zero write-enable leads to `S_READ`;
- select with any write-enable bit set leads to `S_WRITE`.

The decoded state gates the storage banks and the output register. `MASK_BITS` sets how many data bits one enable bit covers. The value 0 means a single enable bit covers the whole word. The data width must be a whole multiple of the group size, and elaboration stops with an error otherwise.

Top module: `sram_sp_masked`

## Requirements
- R1: On a rising edge with `cen_n` low and every `wen` bit low, the output register loads the word stored at `addr`. With `oe` high, `dout` shows that word after the edge.
- R2: On a rising edge with `cen_n` high, no stored word changes and the output register keeps its value, whatever `wen`, `addr` and `din` carry.
- R3: A selected cycle with any `wen` bit high is a write. A selected cycle with all `wen` bits low is a read.
- R4: Group k is data bits `[k*G +: G]`, where G is the group size. In a write, bit `wen[k]` alone decides whether group k of the addressed word takes `din[k*G +: G]`. Groups whose enable is low keep their old stored bits.
- R5: With `MASK_BITS` = 0, `wen` is one bit wide and a write with that bit high replaces the whole word.
- R6: With `oe` low, `dout` is released to high impedance; a bus pull-up then reads all ones. With `oe` high, `dout` shows the output register. A change of `oe` takes effect without waiting for a clock edge.
- R7: During a write cycle the output register keeps its last read value and does not pass write data through.
- R8: While `rst_n` is low, the output register is cleared to zero and the cycle state is `S_IDLE`. Stored words are not cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; everything is sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the output register and cycle state |
| cen_n | input | 1 | Chip select, active low |
| wen | input | NGRP | Per-group write enables; all zero selects a read |
| addr | input | AW | Word address |
| din | input | WIDTH | Write data |
| oe | input | 1 | Output enable, active high |
| dout | output | WIDTH | Read data; high impedance while `oe` is low |

## Verification
A behavioural reference array is run for two instances side by side: a four-group instance and a whole-word instance. The inputs come in several patterns:
- A full-mask fill followed by a sequential read-back separates correct addressing from stuck or aliased words.
- A directed alternating-group write, read back and compared against a hand-built value, shows whether each enable bit reaches its own slice and no other.
- Deselected cycles that carry write data, and write cycles that follow reads, tell a properly gated register and bank apart from one that leaks input data.
- A long random run mixes deselect, read, partial write and output-enable toggling. It exposes ordering faults between decoding and storage, and it checks the released bus against the pull-up value.

// File: rtl/sram_sp_pkg.sv
`timescale 1ns/1ps
package sram_sp_pkg;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_READ  = 2'd1,
        S_WRITE = 2'd2
    } cyc_state_t;

    // Bits per write-enable group; zero selects one group spanning the word.
    function automatic int grp_bits(input int width, input int mask_bits);
        return (mask_bits == 0) ? width : mask_bits;
    endfunction

    function automatic int grp_count(input int width, input int mask_bits);
        return width / grp_bits(width, mask_bits);
    endfunction

endpackage

// File: rtl/sram_sp_ctrl.sv
`timescale 1ns/1ps
module sram_sp_ctrl
    import sram_sp_pkg::*;
#(
    parameter int NGRP = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cen_n,
    input  logic [NGRP-1:0] wen,
    output cyc_state_t      state,
    output logic            rd_go,
    output logic            wr_go
);

    cyc_state_t nxt;

    // Transition choice: deselect -> S_IDLE, any enable -> S_WRITE, else S_READ.
    always_comb begin
        if (cen_n)
            nxt = S_IDLE;
        else if (|wen)
            nxt = S_WRITE;
        else
            nxt = S_READ;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= S_IDLE;
        else
            state <= nxt;
    end

    // Strobes for the datapath, decoded from the state being entered.
    always_comb begin
        rd_go = 1'b0;
        wr_go = 1'b0;
        unique case (nxt)
            S_IDLE:  begin rd_go = 1'b0; wr_go = 1'b0; end
            S_READ:  begin rd_go = 1'b1; wr_go = 1'b0; end
            S_WRITE: begin rd_go = 1'b0; wr_go = 1'b1; end
            default: begin rd_go = 1'b0; wr_go = 1'b0; end
        endcase
    end

endmodule

// File: rtl/sram_sp_array.sv
`timescale 1ns/1ps
module sram_sp_array #(
    parameter int WORDS = 64,
    parameter int GB    = 4,
    parameter int NGRP  = 4,
    localparam int WIDTH = GB * NGRP,
    localparam int AW    = (WORDS > 1) ? $clog2(WORDS) : 1
) (
    input  logic             clk,
    input  logic             wr_go,
    input  logic [NGRP-1:0]  wen,
    input  logic [AW-1:0]    addr,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] rdata
);

    // One independent bank per enable group, so no word is shared by two writers.
    for (genvar g = 0; g < NGRP; g++) begin : g_bank
        logic [GB-1:0] bank [WORDS];

        always_ff @(posedge clk) begin
            if (wr_go && wen[g])
                bank[addr] <= din[g*GB +: GB];
        end

        assign rdata[g*GB +: GB] = bank[addr];
    end

endmodule

// File: rtl/sram_sp_outdrv.sv
`timescale 1ns/1ps
module sram_sp_outdrv #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_go,
    input  logic [WIDTH-1:0] rdata,
    input  logic             oe,
    output logic [WIDTH-1:0] q,
    output logic [WIDTH-1:0] dout
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q <= '0;
        else if (rd_go)
            q <= rdata;
    end

    assign dout = oe ? q : {WIDTH{1'bz}};

endmodule

// File: rtl/sram_sp_masked.sv
`timescale 1ns/1ps
module sram_sp_masked
    import sram_sp_pkg::*;
#(
    parameter int WORDS     = 64,
    parameter int WIDTH     = 16,
    parameter int MASK_BITS = 4,
    localparam int GB   = grp_bits(WIDTH, MASK_BITS),
    localparam int NGRP = grp_count(WIDTH, MASK_BITS),
    localparam int AW   = (WORDS > 1) ? $clog2(WORDS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cen_n,
    input  logic [NGRP-1:0]  wen,
    input  logic [AW-1:0]    addr,
    input  logic [WIDTH-1:0] din,
    input  logic             oe,
    output logic [WIDTH-1:0] dout
);

    if (WIDTH % GB != 0) begin : g_bad_grouping
        $error("WIDTH must be a whole multiple of the write group size");
    end

    cyc_state_t       state;
    logic             rd_go;
    logic             wr_go;
    logic [WIDTH-1:0] rdata;
    logic [WIDTH-1:0] q_reg;

    sram_sp_ctrl #(.NGRP(NGRP)) u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .cen_n (cen_n),
        .wen   (wen),
        .state (state),
        .rd_go (rd_go),
        .wr_go (wr_go)
    );

    sram_sp_array #(.WORDS(WORDS), .GB(GB), .NGRP(NGRP)) u_array (
        .clk   (clk),
        .wr_go (wr_go),
        .wen   (wen),
        .addr  (addr),
        .din   (din),
        .rdata (rdata)
    );

    sram_sp_outdrv #(.WIDTH(WIDTH)) u_outdrv (
        .clk   (clk),
        .rst_n (rst_n),
        .rd_go (rd_go),
        .rdata (rdata),
        .oe    (oe),
        .q     (q_reg),
        .dout  (dout)
    );

endmodule

// File: rtl/sram_sp_chk.sv
`timescale 1ns/1ps
module sram_sp_chk
    import sram_sp_pkg::*;
#(
    parameter int WIDTH = 16,
    parameter int NGRP  = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cen_n,
    input logic [NGRP-1:0]  wen,
    input logic             oe,
    input logic [WIDTH-1:0] dout,
    input logic [WIDTH-1:0] q,
    input cyc_state_t       state
);

    p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cen_n |=> ($stable(q) && state == S_IDLE));

    p_write_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!cen_n && (|wen)) |=> ($stable(q) && state == S_WRITE));

    p_read_class_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!cen_n && wen == '0) |=> state == S_READ);

    p_q_moves_only_on_read_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(q) |-> state == S_READ);

    p_drive_when_enabled_r6: assert property (@(negedge clk) disable iff (!rst_n)
        oe |-> dout == q);

endmodule

bind sram_sp_masked sram_sp_chk #(.WIDTH(WIDTH), .NGRP(NGRP)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .cen_n (cen_n),
    .wen   (wen),
    .oe    (oe),
    .dout  (dout),
    .q     (q_reg),
    .state (state)
);

// File: tb/test_sram_sp_masked.sv
`timescale 1ns/1ps
module test_sram_sp_masked;

    localparam int WORDS = 64;
    localparam int WIDTH = 16;
    localparam int G     = 4;
    localparam int NG    = WIDTH / G;
    localparam int AW    = 6;

    logic             clk   = 1'b0;
    logic             rst_n = 1'b0;
    logic             cen_n = 1'b1;
    logic             oe    = 1'b0;
    logic [NG-1:0]    wen   = '0;
    logic [AW-1:0]    addr  = '0;
    logic [WIDTH-1:0] din   = '0;
    wire  [WIDTH-1:0] dout_m;
    wire  [WIDTH-1:0] dout_f;

    for (genvar b = 0; b < WIDTH; b++) begin : g_pull
        pullup (dout_m[b]);
        pullup (dout_f[b]);
    end

    sram_sp_masked #(.WORDS(WORDS), .WIDTH(WIDTH), .MASK_BITS(G)) i_sram_sp_masked (
        .clk(clk), .rst_n(rst_n), .cen_n(cen_n), .wen(wen), .addr(addr),
        .din(din), .oe(oe), .dout(dout_m)
    );

    sram_sp_masked #(.WORDS(WORDS), .WIDTH(WIDTH), .MASK_BITS(0)) i_sram_sp_masked_full (
        .clk(clk), .rst_n(rst_n), .cen_n(cen_n), .wen(wen[0]), .addr(addr),
        .din(din), .oe(oe), .dout(dout_f)
    );

    always #4 clk = ~clk;

    logic [WIDTH-1:0] mem_m [WORDS];
    logic [WIDTH-1:0] mem_f [WORDS];
    logic [WIDTH-1:0] q_m = '0;
    logic [WIDTH-1:0] q_f = '0;
    int vectors     = 0;
    int miscompares = 0;
    bit done        = 1'b0;

    function automatic logic [WIDTH-1:0] pat(input int i);
        return WIDTH'((i * 16'h0101) ^ 16'h5A3C);
    endfunction

    task automatic chk(input string tag, input logic [WIDTH-1:0] act,
                       input logic [WIDTH-1:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive one cycle at a falling edge, advance the model at the rising edge,
    // compare both instances at the next falling edge.
    task automatic step(input logic c, input logic [NG-1:0] w, input logic [AW-1:0] a,
                        input logic [WIDTH-1:0] d, input logic o, input string tag);
        cen_n = c; wen = w; addr = a; din = d; oe = o;
        @(posedge clk);
        if (!c) begin
            if (|w) begin
                for (int k = 0; k < NG; k++)
                    if (w[k]) mem_m[a][k*G +: G] = d[k*G +: G];
            end else begin
                q_m = mem_m[a];
            end
            if (w[0]) mem_f[a] = d;
            else      q_f = mem_f[a];
        end
        @(negedge clk);
        chk(o ? tag : "R6", dout_m, o ? q_m : '1);
        chk(o ? "R5" : "R6 full", dout_f, o ? q_f : '1);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin : stim
        logic [WIDTH-1:0] old5;
        @(negedge clk);
        oe = 1'b1;
        @(negedge clk);
        #1;
        chk("R8", dout_m, '0);   // reset: output register cleared
        chk("R8", dout_f, '0);
        @(negedge clk);
        rst_n = 1'b1;

        // Full fill; output must hold zero through writes (R7, R3 write class)
        for (int i = 0; i < WORDS; i++) step(1'b0, '1, AW'(i), pat(i), 1'b1, "R7");
        // Sequential read-back (R1, R3 read class)
        for (int i = 0; i < WORDS; i++) begin
            step(1'b0, '0, AW'(i), '0, 1'b1, "R1");
            chk("R1", dout_m, pat(i));
        end

        // Alternating-group write: groups 0 and 2 take F, groups 1 and 3 keep (R4)
        old5 = pat(5);
        step(1'b0, 4'b0101, AW'(5), 16'hFFFF, 1'b1, "R7");
        step(1'b0, '0, AW'(5), '0, 1'b1, "R4");
        chk("R4", dout_m, {old5[15:12], 4'hF, old5[7:4], 4'hF});
        chk("R5", dout_f, 16'hFFFF);   // whole word replaced in single-enable instance

        // Deselected cycle carrying write data: nothing changes (R2)
        step(1'b1, '1, AW'(5), 16'h1234, 1'b1, "R2");
        chk("R2", dout_m, {old5[15:12], 4'hF, old5[7:4], 4'hF});
        step(1'b0, '0, AW'(5), '0, 1'b1, "R2");
        chk("R2", dout_m, {old5[15:12], 4'hF, old5[7:4], 4'hF});

        // Output enable acts without a clock edge (R6)
        oe = 1'b0; #1;
        chk("R6", dout_m, '1);
        oe = 1'b1; #1;
        chk("R6", dout_m, q_m);

        // Single-enable instance: one bit writes the whole word (R5)
        step(1'b0, 4'b0001, AW'(9), 16'hABCD, 1'b1, "R7");
        step(1'b0, '0, AW'(9), '0, 1'b1, "R1");
        chk("R5", dout_f, 16'hABCD);
        chk("R4", dout_m, {pat(9)[15:4], 4'hD});

        // Random mix of deselect, read, partial write and output toggling
        for (int n = 0; n < 3000; n++) begin
            logic c;
            logic [NG-1:0] w;
            string t;
            c = ($urandom_range(3) == 0);
            w = ($urandom_range(1) == 0) ? '0 : NG'($urandom);
            t = c ? "R2" : ((|w) ? "R7" : "R1");
            step(c, w, AW'($urandom), WIDTH'($urandom), ($urandom_range(4) != 0), t);
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule